// File: doc/BRIEF.md
# Multi-format serial audio output

This block turns stereo PCM sample pairs into a three-wire serial audio stream: a bit clock, a word clock and a data line. Each channel occupies a half frame of 32 bit-clock slots. The left channel goes out while the word clock is low and the right channel while it is high. One of four bit arrangements is chosen at run time: I2S, right-justified, left-justified, or raw IEC60958 subframe pass-through. A separate 5-bit width value sets where a right-justified sample sits inside its half frame.

Samples arrive as two 32-bit words with a ready/valid handshake. The block offers to take a new pair only at the last system clock of a frame. A pair that is not offered at that point causes the previous pair to be sent again. The data output is a four-lane bus. Audio uses lane 0. An override routes four auxiliary control bits onto all four lanes instead. A three-state control drops the pad output enable.

Top module: `audio_serial_out`

## Requirements
- R1: Format code 2'b00 (I2S): in each half frame, slot 0 carries 0 and slot k (1..31) carries word bit 32-k, so the MSB follows the word-clock edge by one bit clock.
- R2: Format code 2'b01 (right-justified): slot k carries word bit 31-k when 31-k is below the width value W, and 0 otherwise, so bit 0 lands in slot 31. W = 0 sends only zeros.
- R3: Format code 2'b10 (left-justified): slot k carries word bit 31-k, so the MSB coincides with the word-clock edge.
- R4: Format code 2'b11 (raw): slot k carries word bit k, so the 32-bit subframe goes out unchanged, LSB first.
- R5: The width value resets to 24.
- R6: One bit slot lasts 2*DIV_HALF system clocks, with the bit clock low in the first half of the slot. The word clock is low for slots 0..31 (left) and high for slots 32..63 (right). The word clock and audio data change only together with a falling bit-clock edge.
- R7: pair_ready is high for exactly one system clock, the last clock of a frame, while the bit clock and word clock are both high. A pair offered with pair_valid in that clock is sent in the frame that follows. Format and width are sampled at the same point.
- R8: If no pair is taken at a frame end, the next frame repeats the previous pair bit for bit.
- R9: With the aux override on, sdata equals aux_bits two clocks after the override is written and follows aux_bits one clock later. With the override off, lanes 3..1 are 0.
- R10: With three-state requested, out_en is low two clocks after the write. Clearing the request brings out_en high again.
- R11: After reset: bclk, wclk and sdata are 0, out_en is 1, pair_ready is 0, the format is I2S, and the held pair is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Loads ctrl_mode, ctrl_aux_en, ctrl_hiz |
| ctrl_mode | input | 2 | Format code (see R1-R4 encodings) |
| ctrl_aux_en | input | 1 | Route aux_bits onto the data lanes |
| ctrl_hiz | input | 1 | Request three-state of the audio pads |
| width_wr | input | 1 | Loads width_val |
| width_val | input | 5 | Right-justified sample width |
| aux_bits | input | 4 | Auxiliary control bits |
| left_word | input | 32 | Left channel word |
| right_word | input | 32 | Right channel word |
| pair_valid | input | 1 | Sample pair offered |
| pair_ready | output | 1 | Pair accepted this clock when valid |
| bclk | output | 1 | Bit clock |
| wclk | output | 1 | Word clock (low = left) |
| sdata | output | 4 | Serial data lanes, audio on lane 0 |
| out_en | output | 1 | Pad output enable |

## Verification
The assertions check the framing on every cycle. The word clock moves only together with a falling bit clock, and audio data does the same unless the override is involved. pair_ready is a single-cycle pulse inside the last slot, the spare lanes stay at zero outside the override, and a three-state write drops out_en. The bit-level layout of each format, the right-justified width (including its reset value and the zero case), the repetition of a stale pair and the aux routing are shown only by the bench. It captures whole frames at the bit-clock rising edges and compares them with frames it builds itself from the requirements.

// File: rtl/aso_pkg.sv
package aso_pkg;

    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_RJ  = 2'b01,
        FMT_LJ  = 2'b10,
        FMT_RAW = 2'b11
    } fmt_e;

    localparam int WORD_W   = 32;
    localparam int SLOT_W   = 6;
    localparam int POS_W    = 5;
    localparam int WIDTH_W  = 5;
    localparam logic [WIDTH_W-1:0] WIDTH_RST = 5'd24;

endpackage

// File: rtl/aso_clkgen.sv
module aso_clkgen #(
    parameter int DIV_HALF = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic [aso_pkg::SLOT_W-1:0] slot_d,
    output logic                       bclk_d,
    output logic                       frame_end
);
    localparam int DIV_W = (DIV_HALF < 2) ? 1 : $clog2(2 * DIV_HALF);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(2 * DIV_HALF - 1);
    localparam logic [DIV_W-1:0] DIV_MID  = DIV_W'(DIV_HALF);

    logic [DIV_W-1:0]            div_q, div_d;
    logic [aso_pkg::SLOT_W-1:0]  slot_q;

    always_comb begin
        if (div_q == DIV_LAST) begin
            div_d  = '0;
            slot_d = slot_q + 1'b1;
        end else begin
            div_d  = div_q + 1'b1;
            slot_d = slot_q;
        end
        bclk_d    = (div_d >= DIV_MID);
        frame_end = (div_q == DIV_LAST) && (&slot_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            slot_q <= '0;
        end else begin
            div_q  <= div_d;
            slot_q <= slot_d;
        end
    end

endmodule

// File: rtl/aso_bitsel.sv
module aso_bitsel (
    input  aso_pkg::fmt_e                fmt,
    input  logic [aso_pkg::WIDTH_W-1:0]  width,
    input  logic [aso_pkg::WORD_W-1:0]   word,
    input  logic [aso_pkg::POS_W-1:0]    pos,
    output logic                         bit_o
);
    logic [aso_pkg::POS_W-1:0] rev;

    always_comb begin
        rev = 5'd31 - pos;
        unique case (fmt)
            aso_pkg::FMT_I2S: bit_o = (pos == '0) ? 1'b0 : word[rev + 5'd1];
            aso_pkg::FMT_RJ:  bit_o = (rev < width) ? word[rev] : 1'b0;
            aso_pkg::FMT_LJ:  bit_o = word[rev];
            default:          bit_o = word[pos];
        endcase
    end

endmodule

// File: rtl/audio_serial_out.sv
module audio_serial_out #(
    parameter int DIV_HALF = 2,
    parameter int AUX_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ctrl_wr,
    input  logic [1:0]                  ctrl_mode,
    input  logic                        ctrl_aux_en,
    input  logic                        ctrl_hiz,
    input  logic                        width_wr,
    input  logic [4:0]                  width_val,
    input  logic [AUX_W-1:0]            aux_bits,
    input  logic [31:0]                 left_word,
    input  logic [31:0]                 right_word,
    input  logic                        pair_valid,
    output logic                        pair_ready,
    output logic                        bclk,
    output logic                        wclk,
    output logic [AUX_W-1:0]            sdata,
    output logic                        out_en
);
    import aso_pkg::*;

    typedef struct packed {
        fmt_e                mode;
        logic [WIDTH_W-1:0]  width;
        logic                aux_en;
        logic                hiz;
        fmt_e                act_mode;
        logic [WIDTH_W-1:0]  act_width;
        logic [WORD_W-1:0]   left;
        logic [WORD_W-1:0]   right;
        logic                bclk;
        logic                wclk;
        logic [AUX_W-1:0]    sd;
        logic                oe;
    } st_t;

    st_t st_q, st_d;

    logic [SLOT_W-1:0]  slot_d;
    logic               bclk_d;
    logic               frame_end;
    logic               take;
    logic [WORD_W-1:0]  left_nxt, right_nxt, sel_word;
    fmt_e               sel_fmt;
    logic [WIDTH_W-1:0] sel_width;
    logic               sel_bit;
    logic               aux_on;

    aso_clkgen #(.DIV_HALF(DIV_HALF)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_d    (slot_d),
        .bclk_d    (bclk_d),
        .frame_end (frame_end)
    );

    assign take      = frame_end && pair_valid;
    assign left_nxt  = take ? left_word  : st_q.left;
    assign right_nxt = take ? right_word : st_q.right;
    assign sel_word  = slot_d[SLOT_W-1] ? right_nxt : left_nxt;
    assign sel_fmt   = frame_end ? st_q.mode  : st_q.act_mode;
    assign sel_width = frame_end ? st_q.width : st_q.act_width;

    aso_bitsel u_bitsel (
        .fmt   (sel_fmt),
        .width (sel_width),
        .word  (sel_word),
        .pos   (slot_d[POS_W-1:0]),
        .bit_o (sel_bit)
    );

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.mode   = fmt_e'(ctrl_mode);
            st_d.aux_en = ctrl_aux_en;
            st_d.hiz    = ctrl_hiz;
        end
        if (width_wr) begin
            st_d.width = width_val;
        end
        if (frame_end) begin
            st_d.act_mode  = st_q.mode;
            st_d.act_width = st_q.width;
        end
        st_d.left  = left_nxt;
        st_d.right = right_nxt;
        st_d.bclk  = bclk_d;
        st_d.wclk  = slot_d[SLOT_W-1];
        st_d.sd    = st_q.aux_en ? aux_bits : {{(AUX_W-1){1'b0}}, sel_bit};
        st_d.oe    = !st_q.hiz;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode      <= FMT_I2S;
            st_q.width     <= WIDTH_RST;
            st_q.aux_en    <= 1'b0;
            st_q.hiz       <= 1'b0;
            st_q.act_mode  <= FMT_I2S;
            st_q.act_width <= WIDTH_RST;
            st_q.left      <= '0;
            st_q.right     <= '0;
            st_q.bclk      <= 1'b0;
            st_q.wclk      <= 1'b0;
            st_q.sd        <= '0;
            st_q.oe        <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pair_ready = frame_end;
    assign bclk       = st_q.bclk;
    assign wclk       = st_q.wclk;
    assign sdata      = st_q.sd;
    assign out_en     = st_q.oe;
    assign aux_on     = st_q.aux_en;

endmodule

// File: rtl/aso_checker.sv
module aso_checker #(
    parameter int AUX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic             ctrl_hiz,
    input logic             aux_on,
    input logic             pair_ready,
    input logic             bclk,
    input logic             wclk,
    input logic [AUX_W-1:0] sdata,
    input logic             out_en
);
    AST_WCLK_ON_BCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wclk) |-> $fell(bclk)); // R6

    AST_DATA_ON_BCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!aux_on && !$past(aux_on) && !$past(aux_on, 2) && !$stable(sdata)) |-> $fell(bclk)); // R6

    AST_READY_IN_LAST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ready |-> (bclk && wclk)); // R7

    AST_READY_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ready |=> !pair_ready); // R7

    AST_SPARE_LANES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!aux_on && !$past(aux_on)) |-> (sdata[AUX_W-1:1] == '0)); // R9

    AST_HIZ_DROPS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_hiz ##1 !ctrl_wr) |=> !out_en); // R10

endmodule

bind audio_serial_out aso_checker #(.AUX_W(AUX_W)) u_aso_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_hiz   (ctrl_hiz),
    .aux_on     (aux_on),
    .pair_ready (pair_ready),
    .bclk       (bclk),
    .wclk       (wclk),
    .sdata      (sdata),
    .out_en     (out_en)
);

// File: tb/audio_serial_out_test.sv
module audio_serial_out_test;
    localparam int DIV_HALF = 2;

    typedef struct packed {
        logic [1:0]  mode;
        logic [4:0]  width;
        logic [31:0] l;
        logic [31:0] r;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'b00, 5'd24, 32'hA5C3_9E17, 32'h1234_5678},
        '{2'b10, 5'd24, 32'hDEAD_BEEF, 32'h0F1E_2D3C},
        '{2'b01, 5'd16, 32'hF0F0_ABCD, 32'h8765_4321},
        '{2'b01, 5'd31, 32'hFFFF_FFFF, 32'h8000_0001},
        '{2'b01, 5'd0,  32'hFFFF_FFFF, 32'h5555_5555},
        '{2'b11, 5'd24, 32'h0000_00F1, 32'h8000_0003}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [1:0]  ctrl_mode = 2'b00;
    logic        ctrl_aux_en = 1'b0;
    logic        ctrl_hiz = 1'b0;
    logic        width_wr = 1'b0;
    logic [4:0]  width_val = 5'd0;
    logic [3:0]  aux_bits = 4'h0;
    logic [31:0] left_word = '0;
    logic [31:0] right_word = '0;
    logic        pair_valid = 1'b0;
    logic        pair_ready;
    logic        bclk;
    logic        wclk;
    logic [3:0]  sdata;
    logic        out_en;

    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;
    logic [63:0] cap_data;
    logic [63:0] cap_wclk;
    int          rise_gap;

    always #10 clk = ~clk;

    audio_serial_out #(.DIV_HALF(DIV_HALF), .AUX_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_mode(ctrl_mode),
        .ctrl_aux_en(ctrl_aux_en), .ctrl_hiz(ctrl_hiz), .width_wr(width_wr),
        .width_val(width_val), .aux_bits(aux_bits), .left_word(left_word),
        .right_word(right_word), .pair_valid(pair_valid), .pair_ready(pair_ready),
        .bclk(bclk), .wclk(wclk), .sdata(sdata), .out_en(out_en)
    );

    function automatic logic exp_bit(logic [1:0] m, logic [4:0] w, logic [31:0] wd, int k);
        case (m)
            2'b00:   return (k == 0) ? 1'b0 : wd[32 - k];
            2'b01:   return ((31 - k) < int'(w)) ? wd[31 - k] : 1'b0;
            2'b10:   return wd[31 - k];
            default: return wd[k];
        endcase
    endfunction

    function automatic logic [31:0] exp_half(logic [1:0] m, logic [4:0] w, logic [31:0] wd);
        logic [31:0] h;
        for (int k = 0; k < 32; k++) h[k] = exp_bit(m, w, wd, k);
        return h;
    endfunction

    function automatic string fmt_req(logic [1:0] m);
        case (m)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(logic [1:0] m, logic aux, logic hz);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_mode = m; ctrl_aux_en = aux; ctrl_hiz = hz;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic wr_width(logic [4:0] w);
        @(negedge clk);
        width_wr = 1'b1; width_val = w;
        @(negedge clk);
        width_wr = 1'b0;
    endtask

    task automatic send_pair(logic [31:0] l, logic [31:0] r);
        @(negedge clk);
        left_word = l; right_word = r; pair_valid = 1'b1;
        while (!pair_ready) @(negedge clk);
        @(posedge clk);
        #1 pair_valid = 1'b0;
    endtask

    task automatic capture();
        logic prev;
        int   n;
        int   cyc;
        int   last;
        prev = bclk; n = 0; cyc = 0; last = 0; rise_gap = 0;
        while (n < 64) begin
            @(negedge clk);
            cyc++;
            if (bclk && !prev) begin
                cap_data[n] = sdata[0];
                cap_wclk[n] = wclk;
                if (n == 1) rise_gap = cyc - last;
                last = cyc;
                n++;
            end
            prev = bclk;
        end
    endtask

    task automatic wait_frame_start();
        logic prev;
        prev = wclk;
        forever begin
            @(negedge clk);
            if (!wclk && prev) break;
            prev = wclk;
        end
    endtask

    task automatic check_frame(string req, logic [1:0] m, logic [4:0] w,
                               logic [31:0] l, logic [31:0] r);
        check({req, " left"},  {32'h0, cap_data[31:0]},  {32'h0, exp_half(m, w, l)});
        check({req, " right"}, {32'h0, cap_data[63:32]}, {32'h0, exp_half(m, w, r)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R11: reset state
        check("R11 reset outputs", {59'h0, bclk, wclk, sdata[0], out_en, pair_ready},
              {59'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0});
        check("R11 reset lanes", {60'h0, sdata}, 64'h0);
        rst_n = 1'b1;

        // R11: first frame after reset is I2S of a zero pair
        wait_frame_start();
        capture();
        check("R11 zero pair", cap_data, 64'h0);
        check("R6 word clock", cap_wclk, {{32{1'b1}}, {32{1'b0}}});
        check("R6 slot length", 64'(rise_gap), 64'(2 * DIV_HALF));

        // R5: right-justified without any width write uses 24
        wr_ctrl(2'b01, 1'b0, 1'b0);
        send_pair(32'hFF12_3456, 32'hAB80_0001);
        capture();
        check_frame("R5", 2'b01, 5'd24, 32'hFF12_3456, 32'hAB80_0001);

        // R8: no valid pair offered, the frame repeats
        wait_frame_start();
        capture();
        check_frame("R8", 2'b01, 5'd24, 32'hFF12_3456, 32'hAB80_0001);

        // R1..R4 with R7 handshake: table walk
        for (int i = 0; i < 6; i++) begin
            wr_width(VECS[i].width);
            wr_ctrl(VECS[i].mode, 1'b0, 1'b0);
            send_pair(VECS[i].l, VECS[i].r);
            capture();
            check_frame({fmt_req(VECS[i].mode), " R7"}, VECS[i].mode, VECS[i].width,
                        VECS[i].l, VECS[i].r);
            check("R6 word clock", cap_wclk, {{32{1'b1}}, {32{1'b0}}});
        end

        // R9: aux override
        aux_bits = 4'b1011;
        wr_ctrl(2'b10, 1'b1, 1'b0);
        @(negedge clk);
        check("R9 aux on", {60'h0, sdata}, {60'h0, 4'b1011});
        aux_bits = 4'b0110;
        @(negedge clk);
        check("R9 aux follow", {60'h0, sdata}, {60'h0, 4'b0110});
        wr_ctrl(2'b10, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 aux off spare lanes", {61'h0, sdata[3:1]}, 64'h0);

        // R10: three-state
        wr_ctrl(2'b10, 1'b0, 1'b1);
        @(negedge clk);
        check("R10 oe low", {63'h0, out_en}, 64'h0);
        wr_ctrl(2'b10, 1'b0, 1'b0);
        @(negedge clk);
        check("R10 oe high", {63'h0, out_en}, 64'h1);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule